// File: doc/BRIEF.md
# Rotational Sector Position Counter

This block follows the angular position of a head-per-track disk or drum. It is driven by a free-running word-time strobe. It keeps a word index within the current revolution and derives the sector number that will next pass under the heads. The value it reports is deliberately one ahead of the sector in disk geometry. Each revolution opens with a short overhead gap, during which the reported sector number is zero.

The block also produces two diagnostic conditions, and both exist only in disk geometry.
- The phase flag marks the closing word times of each sector, when the sector has become too late to start an access.
- The origin flag records that the media has passed track origin since software last cleared it.

A mode input selects disk geometry (90 sectors) or drum geometry (32 sectors). A controller reads the outputs to schedule transfers and to run its rotational self-tests.

Top module: `rot_sector_position`

## Requirements
- R1: While rst_ni is low, word_idx_o is 0, next_sec_o is 0, and phase_o and origin_o are 0.
- R2: On a clock edge with word_tick_i high, word_idx_o advances by one. It holds when word_tick_i is low. This applies only when the mode is unchanged.
- R3: A revolution is 64 × sectors + 5 word times. When word_idx_o is 5764 (disk) or 2052 (drum), a tick returns it to 0.
- R4: For word indices 0 to 4 (the overhead gap), next_sec_o is 0.
- R5: In disk mode (drum_mode_i = 0), for a word index w ≥ 5, next_sec_o = (w − 5) / 64 + 1, with integer division. Its range is therefore 1 to 90.
- R6: In drum mode (drum_mode_i = 1), for w ≥ 5, next_sec_o = (w − 5) / 64. Its range is therefore 0 to 31.
- R7: In disk mode, phase_o is 1 exactly when w ≥ 5 and (w − 5) mod 64 is 61, 62 or 63. Those are the last 3 word times of each sector.
- R8: In disk mode, origin_o is set at the edge where a tick wraps the word index to 0. It then stays set until it is cleared.
- R9: A clock edge with org_clr_i high leaves origin_o at 0. This holds even if the same edge wraps the word index, so detection re-arms for the next origin.
- R10: In drum mode, phase_o and origin_o are always 0.
- R11: drum_mode_i is sampled at each clock edge. An edge where it differs from the mode in use restarts the word index at 0 and clears origin_o. The new geometry governs the outputs from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_tick_i | input | 1 | One-cycle strobe per word time |
| drum_mode_i | input | 1 | 0 = disk geometry, 1 = drum geometry |
| org_clr_i | input | 1 | Clears the origin flag and re-arms detection |
| next_sec_o | output | 7 | Sector number that will next pass the heads |
| word_idx_o | output | 13 | Word index within the revolution |
| phase_o | output | 1 | Sector clock phase: last 3 words of a sector |
| origin_o | output | 1 | Track origin passed since the last clear |

## Verification
The assertions check the following every cycle:
- single-step advance and hold of the word index;
- its wrap at the geometry's last word;
- a zero sector count inside the gap;
- the ceiling on the sector count;
- silence of both flags in drum mode;
- the clear and hold behaviour of the origin flag;
- the restart on a mode change.

The exact sector number at each word, the position of the phase window at sector boundaries, and the clear-versus-wrap collision need the bench's reference model. The model is run over complete revolutions in both geometries and through random tick, clear and mode patterns.

// File: rtl/rot_pkg.sv
package rot_pkg;
  localparam int WORDS_PER_SEC = 64;  // must be a power of two
  localparam int DISK_SECS     = 90;
  localparam int DRUM_SECS     = 32;
  localparam int GAP_WORDS     = 5;
  localparam int PHASE_WORDS   = 3;

  typedef enum logic {
    GEOM_DISK = 1'b0,
    GEOM_DRUM = 1'b1
  } geom_e;
endpackage

// File: rtl/rot_word_counter.sv
module rot_word_counter #(
  parameter int POS_W     = 13,
  parameter int DISK_LAST = 5764,
  parameter int DRUM_LAST = 2052
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             drum_i,
  output logic [POS_W-1:0] pos_o,
  output logic             drum_o,
  output logic             wrap_o,
  output logic             restart_o
);
  logic [POS_W-1:0] pos_q;
  logic             drum_q;
  logic [POS_W-1:0] last;

  assign last      = drum_q ? POS_W'(DRUM_LAST) : POS_W'(DISK_LAST);
  assign restart_o = (drum_i != drum_q);
  assign wrap_o    = tick_i && !restart_o && (pos_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      drum_q <= rot_pkg::GEOM_DISK;
    end else if (restart_o) begin
      pos_q  <= '0;
      drum_q <= drum_i;
    end else if (tick_i) begin
      pos_q <= wrap_o ? '0 : pos_q + 1'b1;
    end
  end

  assign pos_o  = pos_q;
  assign drum_o = drum_q;
endmodule

// File: rtl/rot_sector_decode.sv
module rot_sector_decode #(
  parameter int POS_W  = 13,
  parameter int SEC_W  = 7,
  parameter int WPS    = 64,
  parameter int GAP    = 5,
  parameter int PHASE  = 3
) (
  input  logic [POS_W-1:0] pos_i,
  input  logic             drum_i,
  output logic [SEC_W-1:0] next_sec_o,
  output logic             phase_o
);
  localparam int SHIFT = $clog2(WPS);

  logic [POS_W-1:0] rel;
  logic [SEC_W-1:0] sec;
  logic [SHIFT-1:0] word;

  always_comb begin
    rel        = pos_i - POS_W'(GAP);
    sec        = SEC_W'(rel >> SHIFT);
    word       = rel[SHIFT-1:0];
    next_sec_o = '0;
    phase_o    = 1'b0;
    if (pos_i >= POS_W'(GAP)) begin
      // disk geometry reports one ahead of the sector under the heads
      next_sec_o = drum_i ? sec : sec + 1'b1;
      phase_o    = !drum_i && (word >= SHIFT'(WPS - PHASE));
    end
  end
endmodule

// File: rtl/rot_origin_flag.sv
module rot_origin_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wrap_i,
  input  logic restart_i,
  input  logic clr_i,
  input  logic drum_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           flag_q <= 1'b0;
    else if (restart_i || clr_i || drum_i) flag_q <= 1'b0;
    else if (wrap_i)                       flag_q <= 1'b1;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/rot_sector_position.sv
module rot_sector_position #(
  parameter int WORDS_PER_SEC = rot_pkg::WORDS_PER_SEC,
  parameter int DISK_SECS     = rot_pkg::DISK_SECS,
  parameter int DRUM_SECS     = rot_pkg::DRUM_SECS,
  parameter int GAP_WORDS     = rot_pkg::GAP_WORDS,
  parameter int PHASE_WORDS   = rot_pkg::PHASE_WORDS
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       word_tick_i,
  input  logic       drum_mode_i,
  input  logic       org_clr_i,
  output logic [6:0] next_sec_o,
  output logic [12:0] word_idx_o,
  output logic       phase_o,
  output logic       origin_o
);
  localparam int DISK_REV  = WORDS_PER_SEC * DISK_SECS + GAP_WORDS;
  localparam int DRUM_REV  = WORDS_PER_SEC * DRUM_SECS + GAP_WORDS;
  localparam int POS_W     = $clog2(DISK_REV);
  localparam int SEC_W     = $clog2(DISK_SECS + 1);

  logic [POS_W-1:0] pos;
  logic [SEC_W-1:0] sec;
  logic             drum_q;
  logic             wrap;
  logic             restart;

  rot_word_counter #(
    .POS_W(POS_W), .DISK_LAST(DISK_REV - 1), .DRUM_LAST(DRUM_REV - 1)
  ) u_cnt (
    .clk_i, .rst_ni, .tick_i(word_tick_i), .drum_i(drum_mode_i),
    .pos_o(pos), .drum_o(drum_q), .wrap_o(wrap), .restart_o(restart)
  );

  rot_sector_decode #(
    .POS_W(POS_W), .SEC_W(SEC_W), .WPS(WORDS_PER_SEC),
    .GAP(GAP_WORDS), .PHASE(PHASE_WORDS)
  ) u_dec (
    .pos_i(pos), .drum_i(drum_q), .next_sec_o(sec), .phase_o(phase_o)
  );

  rot_origin_flag u_org (
    .clk_i, .rst_ni, .wrap_i(wrap), .restart_i(restart),
    .clr_i(org_clr_i), .drum_i(drum_q), .flag_o(origin_o)
  );

  assign next_sec_o = 7'(sec);
  assign word_idx_o = 13'(pos);
endmodule

// File: rtl/rot_sector_position_chk.sv
module rot_sector_position_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        word_tick_i,
  input logic        drum_mode_i,
  input logic        org_clr_i,
  input logic [6:0]  next_sec_o,
  input logic [12:0] word_idx_o,
  input logic        phase_o,
  input logic        origin_o,
  input logic        drum_q
);
  localparam logic [12:0] DISK_LAST = 13'(rot_pkg::WORDS_PER_SEC * rot_pkg::DISK_SECS + rot_pkg::GAP_WORDS - 1);
  localparam logic [12:0] DRUM_LAST = 13'(rot_pkg::WORDS_PER_SEC * rot_pkg::DRUM_SECS + rot_pkg::GAP_WORDS - 1);

  logic [12:0] last;
  logic        same;
  assign last = drum_q ? DRUM_LAST : DISK_LAST;
  assign same = (drum_mode_i == drum_q);

  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!word_tick_i && same) |=> $stable(word_idx_o)); // R2

  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_tick_i && same && word_idx_o != last) |=> (word_idx_o == $past(word_idx_o) + 13'd1)); // R2

  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_tick_i && same && word_idx_o == last) |=> (word_idx_o == 13'd0)); // R3

  AST_GAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_idx_o < 13'd5) |-> (next_sec_o == 7'd0)); // R4

  AST_SEC_CEILING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    next_sec_o <= (drum_q ? 7'd31 : 7'd90)); // R5

  AST_DRUM_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drum_q |-> (!phase_o && !origin_o)); // R10

  AST_ORG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (origin_o && !org_clr_i && same) |=> origin_o); // R8

  AST_ORG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    org_clr_i |=> !origin_o); // R9

  AST_MODE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !same |=> (word_idx_o == 13'd0 && !origin_o)); // R11
endmodule

bind rot_sector_position rot_sector_position_chk u_chk (
  .clk_i, .rst_ni, .word_tick_i, .drum_mode_i, .org_clr_i,
  .next_sec_o, .word_idx_o, .phase_o, .origin_o, .drum_q(drum_q)
);

// File: tb/sim_rot_sector_position.sv
`timescale 1ns/1ps
module sim_rot_sector_position;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        word_tick_i = 1'b0;
  logic        drum_mode_i = 1'b0;
  logic        org_clr_i = 1'b0;
  logic [6:0]  next_sec_o;
  logic [12:0] word_idx_o;
  logic        phase_o;
  logic        origin_o;

  int n_chk = 0;
  int n_fail = 0;
  int m_pos = 0;
  bit m_drum = 1'b0;
  bit m_org = 1'b0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  rot_sector_position u0 (.*);

  function automatic int f_last(bit drum);
    return drum ? 64 * 32 + 5 - 1 : 64 * 90 + 5 - 1;
  endfunction

  function automatic int f_next(int w, bit drum);
    if (w < 5) return 0;
    return (w - 5) / 64 + (drum ? 0 : 1);
  endfunction

  function automatic bit f_phase(int w, bit drum);
    if (drum || w < 5) return 1'b0;
    return ((w - 5) % 64) >= 61;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (word %0d)", tag, act, exp, m_pos);
    end
  endtask

  task automatic check_all();
    chk(int'(word_idx_o) == m_pos, "R2/R3 word index", int'(word_idx_o), m_pos);
    chk(int'(next_sec_o) == f_next(m_pos, m_drum),
        (m_pos < 5) ? "R4 gap sector" : (m_drum ? "R6 drum sector" : "R5 disk sector"),
        int'(next_sec_o), f_next(m_pos, m_drum));
    chk(phase_o == f_phase(m_pos, m_drum), m_drum ? "R10 drum phase" : "R7 phase",
        int'(phase_o), int'(f_phase(m_pos, m_drum)));
    chk(origin_o == m_org, m_drum ? "R10 drum origin" : "R8/R9 origin",
        int'(origin_o), int'(m_org));
  endtask

  // drive at negedge, model after posedge, check at next negedge
  task automatic cyc(bit tick, bit drum, bit clr);
    bit wrap;
    word_tick_i = tick;
    drum_mode_i = drum;
    org_clr_i   = clr;
    @(posedge clk_i);
    wrap = 1'b0;
    if (drum != m_drum) begin
      m_drum = drum; m_pos = 0; m_org = 1'b0;   // R11
    end else begin
      if (tick) begin
        if (m_pos == f_last(m_drum)) begin m_pos = 0; wrap = 1'b1; end
        else m_pos++;
      end
      if (clr || m_drum) m_org = 1'b0;
      else if (wrap) m_org = 1'b1;
    end
    @(negedge clk_i);
    check_all();
  endtask

  initial begin
    process::self().srandom(32'd1977);
    #1;
    @(negedge clk_i);
    // R1 reset state
    chk(word_idx_o == 0, "R1 word index", int'(word_idx_o), 0);
    chk(next_sec_o == 0, "R1 sector", int'(next_sec_o), 0);
    chk(!phase_o && !origin_o, "R1 flags", int'({phase_o, origin_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all();

    // R2 hold without tick
    repeat (4) cyc(1'b0, 1'b0, 1'b0);
    // full disk revolution plus a bit: R3 R4 R5 R7 R8
    repeat (5765 + 200) cyc(1'b1, 1'b0, 1'b0);
    // R9 clear mid revolution, then ride to next origin
    cyc(1'b1, 1'b0, 1'b1);
    while (m_pos != 5764) cyc(1'b1, 1'b0, 1'b0);
    // R9 clear on the very wrap edge wins
    cyc(1'b1, 1'b0, 1'b1);
    chk(origin_o == 1'b0 && word_idx_o == 0, "R9 clear at wrap", int'(origin_o), 0);
    repeat (5765) cyc(1'b1, 1'b0, 1'b0);
    chk(origin_o == 1'b1, "R8 origin after wrap", int'(origin_o), 1);
    // R11 switch to drum mid revolution; R6 R10 over full drum revolutions
    repeat (300) cyc(1'b1, 1'b0, 1'b0);
    cyc(1'b1, 1'b1, 1'b0);
    chk(word_idx_o == 0 && origin_o == 0, "R11 restart on mode change", int'(word_idx_o), 0);
    repeat (2 * 2053 + 10) cyc(1'b1, 1'b1, 1'b0);
    // back to disk
    cyc(1'b0, 1'b0, 1'b0);
    // constrained random mix
    for (int i = 0; i < 20000; i++) begin
      bit t, c, d;
      t = ($urandom % 4) != 0;
      c = ($urandom % 97) == 0;
      d = (($urandom % 3001) == 0) ? !m_drum : m_drum;
      cyc(t, d, c);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule